// File: doc/BRIEF.md
# Protected Scratchpad Write Controller

This block takes the byte stream of a write-to-scratchpad transaction and fills an eight-byte volatile staging buffer from it. The first byte must be the write command code. The next two bytes form a 16-bit target address. Every byte after that is data. Before a data byte is stored, it is combined with the byte the array already holds at the same address. How it is combined depends on a protection code for the page that owns that address. The memory side supplies both the stored byte and the protection code through a read-only lookup port.

While the stream arrives, the block keeps a transfer-status byte and a running CRC-16. The status byte holds the offset of the last byte written, an incomplete-row flag and a copied flag. The CRC covers everything sent, starting with the command byte. The bit-level bus front end, the copy into non-volatile storage and the array's programming timing all belong to other blocks. A separate strobe marks the end of each transaction.

Top module: `sp_write_ctrl`

## Requirements
- R1: After reset the buffer and target address read as zero, the status byte reads 20h (incomplete flag set, everything else clear), and the CRC-ready flag is low.
- R2: The first byte after reset or after an end strobe must equal 0Fh. Any other first byte causes every byte up to the next end strobe to be ignored, which leaves the buffer, the address, the status and the CRC outputs unchanged.
- R3: The second byte of the transaction becomes address bits 7:0 and the third becomes bits 15:8. The address output changes on no other byte.
- R4: Data bytes go into consecutive buffer offsets, starting at address bits 2:0. Once offset 7 has been written, further data bytes in the same transaction are ignored.
- R5: Status bits 2:0 take address bits 2:0 when the third byte arrives. After each stored data byte they hold the offset of that byte.
- R6: A byte aimed at a page whose protection code is neither 55h nor AAh is stored exactly as sent.
- R7: Addresses 00h to 7Fh form four 32-byte pages. The page index is address bits 6:5 and goes out on `prot_idx`. With protection code 55h the stored array byte is loaded and the incoming byte is dropped. With code AAh the bitwise AND of the two is loaded.
- R8: In the control row at addresses 80h to 87h, a location whose stored byte is 55h or AAh keeps that stored byte, and any other location takes the byte as sent. All addresses above 87h take the byte as sent.
- R9: The incomplete flag (status bit 5) sets when the third byte arrives. It clears only when a byte is stored at offset 7.
- R10: The copied flag (status bit 7) sets on a `copied` pulse and clears when any data byte is stored. Status bits 3, 4 and 6 always read 0.
- R11: The CRC-16 uses the reflected polynomial A001h, starts from zero at the command byte, and is updated LSB first with the address bytes and every stored data byte. `crc_out` carries its bitwise inverse. `crc_vld` rises when offset 7 is stored and falls at the next accepted command byte.
- R12: The end strobe returns the block to waiting for a command byte. A byte presented in the same cycle as the end strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` carries a full received byte |
| byte_data | input | 8 | Received byte |
| cmd_end | input | 1 | One-cycle end-of-transaction strobe |
| copied | input | 1 | Pulse from the copy engine that sets the copied flag |
| arr_addr | output | 16 | Array address that the next data byte will merge with |
| arr_rdata | input | 8 | Stored array byte at `arr_addr`, valid in the same cycle |
| prot_idx | output | $clog2(NUM_PAGES) | Page index whose protection code is requested |
| prot_code | input | 8 | Protection code of page `prot_idx`, valid in the same cycle |
| sp_data | output | SP_BYTES*8 | Buffer contents, offset i at bits 8i+7:8i |
| ta | output | 16 | Target address |
| es | output | 8 | Status: {copied, 0, incomplete, 0, 0, last offset} |
| crc_out | output | 16 | Inverted running CRC-16 |
| crc_vld | output | 1 | High while the inverted CRC may be read |

## Verification
The assertions watch properties that hold in every cycle. The CRC-ready flag only appears together with a last offset of 7 and a cleared incomplete flag. The buffer and the address move only on bytes that were accepted into their phase. Any stored byte leaves the copied flag clear. Only the bench scenarios can show that the merged values, the starting offset and the CRC value are correct. Those scenarios cover each protection code, the control row, unmapped addresses, short and overlong rows, a rejected command and a byte that collides with the end strobe. Each result is compared against a reference model kept in the bench.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_TA1,
    PH_TA2,
    PH_DATA,
    PH_DONE,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    PM_OPEN,
    PM_LOCK,
    PM_ANDM
  } pmode_t;

  localparam logic [7:0]  CMD_WRITE_SP  = 8'h0F;
  localparam logic [7:0]  CODE_LOCK     = 8'h55;
  localparam logic [7:0]  CODE_ANDM     = 8'hAA;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // One byte through the reflected CRC-16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                             input logic [7:0]  b);
    logic [15:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ b[k]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/spw_phase.sv
module spw_phase
  import spw_pkg::*;
#(
  parameter logic [7:0] CMD_CODE = CMD_WRITE_SP
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       cmd_end,
  input  logic       last_slot,
  output logic       take_cmd,
  output logic       take_ta1,
  output logic       take_ta2,
  output logic       take_data
);

  phase_t phase_q;
  logic   live;

  // A byte in the same cycle as the end strobe is discarded.
  assign live      = byte_vld && !cmd_end;
  assign take_cmd  = live && (phase_q == PH_CMD) && (byte_data == CMD_CODE);
  assign take_ta1  = live && (phase_q == PH_TA1);
  assign take_ta2  = live && (phase_q == PH_TA2);
  assign take_data = live && (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CMD;
    end else if (cmd_end) begin
      phase_q <= PH_CMD;
    end else if (byte_vld) begin
      case (phase_q)
        PH_CMD:  phase_q <= (byte_data == CMD_CODE) ? PH_TA1 : PH_SKIP;
        PH_TA1:  phase_q <= PH_TA2;
        PH_TA2:  phase_q <= PH_DATA;
        PH_DATA: if (last_slot) phase_q <= PH_DONE;
        default: phase_q <= phase_q;
      endcase
    end
  end

endmodule

// File: rtl/spw_status.sv
module spw_status #(
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_ta2,
  input  logic             take_data,
  input  logic             copied,
  input  logic [OFF_W-1:0] ta_lo,
  output logic [OFF_W-1:0] wr_ptr,
  output logic             last_slot,
  output logic [7:0]       es
);

  localparam int PF_BIT = 5;
  localparam int AA_BIT = 7;

  logic [OFF_W-1:0] end_q;
  logic [OFF_W-1:0] ptr_q;
  logic             pf_q;
  logic             aa_q;

  assign wr_ptr    = ptr_q;
  assign last_slot = (ptr_q == {OFF_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q <= '0;
      ptr_q <= '0;
      pf_q  <= 1'b1;
      aa_q  <= 1'b0;
    end else begin
      if (take_ta2) begin
        ptr_q <= ta_lo;
        end_q <= ta_lo;
        pf_q  <= 1'b1;
      end
      if (take_data) begin
        end_q <= ptr_q;
        ptr_q <= ptr_q + 1'b1;
        if (last_slot) pf_q <= 1'b0;
      end
      if (take_data)   aa_q <= 1'b0;
      else if (copied) aa_q <= 1'b1;
    end
  end

  always_comb begin
    es                = '0;
    es[OFF_W-1:0]     = end_q;
    es[PF_BIT]        = pf_q;
    es[AA_BIT]        = aa_q;
  end

endmodule

// File: rtl/spw_merge.sv
module spw_merge
  import spw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SP_BYTES   = 8,
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 4
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   stored,
  input  logic [7:0]                   code,
  input  logic [7:0]                   din,
  output logic [$clog2(NUM_PAGES)-1:0] prot_idx,
  output logic [7:0]                   merged
);

  localparam int OFF_W      = $clog2(SP_BYTES);
  localparam int PAGE_OFF_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = $clog2(NUM_PAGES);
  localparam int DATA_SPAN  = NUM_PAGES * PAGE_BYTES;
  localparam logic [ADDR_W-1:0]       SPAN_A = ADDR_W'(DATA_SPAN);
  localparam logic [ADDR_W-OFF_W-1:0] CTRL_ROW = (ADDR_W-OFF_W)'(DATA_SPAN >> OFF_W);

  logic   in_pages;
  logic   in_ctrl;
  pmode_t mode;

  assign in_pages = (addr < SPAN_A);
  assign in_ctrl  = (addr[ADDR_W-1:OFF_W] == CTRL_ROW);
  assign prot_idx = addr[PAGE_OFF_W +: PAGE_W];

  always_comb begin
    mode = PM_OPEN;
    if (in_pages) begin
      if (code == CODE_LOCK)      mode = PM_LOCK;
      else if (code == CODE_ANDM) mode = PM_ANDM;
    end else if (in_ctrl) begin
      // A control byte that holds either lock code is itself frozen.
      if (stored == CODE_LOCK || stored == CODE_ANDM) mode = PM_LOCK;
    end
  end

  always_comb begin
    case (mode)
      PM_LOCK: merged = stored;
      PM_ANDM: merged = stored & din;
      default: merged = din;
    endcase
  end

endmodule

// File: rtl/spw_crc.sv
module spw_crc
  import spw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take_cmd,
  input  logic        take_upd,
  input  logic [7:0]  byte_data,
  output logic [15:0] crc_inv
);

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)           crc_q <= '0;
    else if (take_cmd) crc_q <= crc16_step(16'h0000, byte_data);
    else if (take_upd) crc_q <= crc16_step(crc_q, byte_data);
  end

  assign crc_inv = ~crc_q;

endmodule

// File: rtl/sp_write_ctrl.sv
module sp_write_ctrl
  import spw_pkg::*;
#(
  parameter int SP_BYTES   = 8,
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         byte_vld,
  input  logic [7:0]                   byte_data,
  input  logic                         cmd_end,
  input  logic                         copied,
  output logic [15:0]                  arr_addr,
  input  logic [7:0]                   arr_rdata,
  output logic [$clog2(NUM_PAGES)-1:0] prot_idx,
  input  logic [7:0]                   prot_code,
  output logic [SP_BYTES*8-1:0]        sp_data,
  output logic [15:0]                  ta,
  output logic [7:0]                   es,
  output logic [15:0]                  crc_out,
  output logic                         crc_vld
);

  localparam int ADDR_W = 16;
  localparam int OFF_W  = $clog2(SP_BYTES);

  logic             take_cmd, take_ta1, take_ta2, take_data;
  logic             last_slot;
  logic [OFF_W-1:0] wr_ptr;
  logic [15:0]      ta_q;
  logic [7:0]       merged;
  logic [7:0]       sp_q [SP_BYTES];
  logic             crc_vld_q;

  spw_phase #(.CMD_CODE(CMD_WRITE_SP)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .cmd_end   (cmd_end),
    .last_slot (last_slot),
    .take_cmd  (take_cmd),
    .take_ta1  (take_ta1),
    .take_ta2  (take_ta2),
    .take_data (take_data)
  );

  spw_status #(.OFF_W(OFF_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .take_ta2  (take_ta2),
    .take_data (take_data),
    .copied    (copied),
    .ta_lo     (ta_q[OFF_W-1:0]),
    .wr_ptr    (wr_ptr),
    .last_slot (last_slot),
    .es        (es)
  );

  assign arr_addr = {ta_q[ADDR_W-1:OFF_W], wr_ptr};

  spw_merge #(
    .ADDR_W     (ADDR_W),
    .SP_BYTES   (SP_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
  ) u_merge (
    .addr     (arr_addr),
    .stored   (arr_rdata),
    .code     (prot_code),
    .din      (byte_data),
    .prot_idx (prot_idx),
    .merged   (merged)
  );

  spw_crc u_crc (
    .clk       (clk),
    .rst       (rst),
    .take_cmd  (take_cmd),
    .take_upd  (take_ta1 | take_ta2 | take_data),
    .byte_data (byte_data),
    .crc_inv   (crc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ta_q <= '0;
    end else begin
      if (take_ta1) ta_q[7:0]  <= byte_data;
      if (take_ta2) ta_q[15:8] <= byte_data;
    end
  end
  assign ta = ta_q;

  generate
    for (genvar i = 0; i < SP_BYTES; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)                                           sp_q[i] <= '0;
        else if (take_data && (wr_ptr == OFF_W'(i)))       sp_q[i] <= merged;
      end
      assign sp_data[8*i +: 8] = sp_q[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                         crc_vld_q <= 1'b0;
    else if (take_cmd)               crc_vld_q <= 1'b0;
    else if (take_data && last_slot) crc_vld_q <= 1'b1;
  end
  assign crc_vld = crc_vld_q;

  AST_CRC_AT_END: assert property (@(posedge clk) disable iff (rst)
    crc_vld |-> (es[OFF_W-1:0] == {OFF_W{1'b1}}));                 // R11
  AST_PF_LOW_AT_END: assert property (@(posedge clk) disable iff (rst)
    crc_vld |-> !es[5]);                                            // R9
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take_data |=> $stable(sp_data));                               // R4
  AST_TA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(take_ta1 || take_ta2) |=> $stable(ta));                       // R3
  AST_AA_CLEARED: assert property (@(posedge clk) disable iff (rst)
    take_data |=> !es[7]);                                          // R10

endmodule

// File: tb/sp_write_ctrl_test.sv
module sp_write_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        cmd_end = 1'b0;
  logic        copied = 1'b0;
  logic [15:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic [1:0]  prot_idx;
  logic [7:0]  prot_code;
  logic [63:0] sp_data;
  logic [15:0] ta;
  logic [7:0]  es;
  logic [15:0] crc_out;
  logic        crc_vld;

  logic [7:0] mem [0:255];
  assign arr_rdata = mem[arr_addr[7:0]];
  assign prot_code = mem[8'h80 | {6'd0, prot_idx}];

  sp_write_ctrl uut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .cmd_end(cmd_end), .copied(copied), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .prot_idx(prot_idx), .prot_code(prot_code),
    .sp_data(sp_data), .ta(ta), .es(es), .crc_out(crc_out), .crc_vld(crc_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]  e_sp [0:7];
  logic [15:0] e_ta, e_crc;
  logic [2:0]  e_e, e_ptr;
  logic        e_pf, e_aa, e_cv, e_done;
  logic [7:0]  dbuf [0:15];

  function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ b[k]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_merge(input logic [15:0] a, input logic [7:0] din);
    logic [7:0] code, st;
    st = mem[a[7:0]];
    if (a < 16'h0080) begin
      code = mem[8'h80 | {6'd0, a[6:5]}];
      if (code == 8'h55)      return st;
      else if (code == 8'hAA) return st & din;
      else                    return din;
    end else if (a[15:3] == 13'h0010) begin
      if (st == 8'h55 || st == 8'hAA) return st;
      else                            return din;
    end
    return din;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [63:0] flat;
    for (int i = 0; i < 8; i++) flat[8*i +: 8] = e_sp[i];
    chk({req, " buffer"}, sp_data, flat);
    chk({req, " address"}, {48'd0, ta}, {48'd0, e_ta});
    chk({req, " status"}, {56'd0, es}, {56'd0, e_aa, 1'b0, e_pf, 2'b00, e_e});
    chk({req, " crc ready"}, {63'd0, crc_vld}, {63'd0, e_cv});
    if (e_cv) chk({req, " crc value"}, {48'd0, crc_out}, {48'd0, ~e_crc});
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic [15:0] tav,
                         input int n, input bit collide);
    logic ok;
    logic [15:0] a;
    ok = (cmd == 8'h0F);
    put_byte(cmd);
    if (ok) begin e_crc = ref_crc(16'h0000, cmd); e_cv = 1'b0; end
    put_byte(tav[7:0]);
    if (ok) begin e_ta[7:0] = tav[7:0]; e_crc = ref_crc(e_crc, tav[7:0]); end
    put_byte(tav[15:8]);
    if (ok) begin
      e_ta[15:8] = tav[15:8];
      e_crc  = ref_crc(e_crc, tav[15:8]);
      e_e    = tav[2:0];
      e_ptr  = tav[2:0];
      e_pf   = 1'b1;
      e_done = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      put_byte(dbuf[i]);
      if (ok && !e_done) begin
        a = {e_ta[15:3], e_ptr};
        e_sp[e_ptr] = ref_merge(a, dbuf[i]);
        e_e   = e_ptr;
        e_aa  = 1'b0;
        e_crc = ref_crc(e_crc, dbuf[i]);
        if (e_ptr == 3'd7) begin e_pf = 1'b0; e_cv = 1'b1; e_done = 1'b1; end
        e_ptr = e_ptr + 3'd1;
      end
    end
    @(negedge clk);
    cmd_end = 1'b1;
    if (collide) begin byte_vld = 1'b1; byte_data = 8'h5A; end
    @(negedge clk);
    cmd_end  = 1'b0;
    byte_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    int sel;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[8'h80] = 8'h00; mem[8'h81] = 8'h55; mem[8'h82] = 8'hAA; mem[8'h83] = 8'h3C;
    mem[8'h84] = 8'h55; mem[8'h85] = 8'hAA; mem[8'h86] = 8'h12; mem[8'h87] = 8'h77;
    for (int i = 0; i < 8; i++) e_sp[i] = 8'h00;
    e_ta = '0; e_crc = '0; e_e = '0; e_ptr = '0;
    e_pf = 1'b1; e_aa = 1'b0; e_cv = 1'b0; e_done = 1'b0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    fill(8); run_cmd(8'h0F, 16'h0000, 8, 1'b0); check_all("R4 R5 R6 R9 R11 open page full row");
    fill(8); run_cmd(8'h0F, 16'h0020, 8, 1'b0); check_all("R7 locked page");
    fill(8); run_cmd(8'h0F, 16'h0048, 8, 1'b0); check_all("R7 and-merge page");
    fill(8); run_cmd(8'h0F, 16'h0060, 8, 1'b0); check_all("R6 other code open");
    fill(2); run_cmd(8'h0F, 16'h0005, 2, 1'b0); check_all("R5 R9 R11 short row");
    fill(6); run_cmd(8'h0F, 16'h0005, 6, 1'b0); check_all("R4 overlong row");
    fill(8); run_cmd(8'h0F, 16'h0080, 8, 1'b0); check_all("R8 control row");
    fill(8); run_cmd(8'h0F, 16'h1230, 8, 1'b0); check_all("R8 unmapped open");
    fill(4); run_cmd(8'hF0, 16'h0000, 4, 1'b0); check_all("R2 rejected command");

    @(negedge clk); copied = 1'b1;
    @(negedge clk); copied = 1'b0;
    e_aa = 1'b1;
    check_all("R10 copied set");
    run_cmd(8'h0F, 16'h0040, 0, 1'b0); check_all("R10 R3 address only keeps flag");
    fill(1); run_cmd(8'h0F, 16'h0040, 1, 1'b0); check_all("R10 data clears flag");
    fill(2); run_cmd(8'h0F, 16'h0008, 2, 1'b1); check_all("R12 byte with end strobe");

    for (int it = 0; it < 40; it++) begin
      sel = int'($urandom % 4);
      case (sel)
        0:       a = 16'($urandom % 128);
        1:       a = 16'h0080 + 16'($urandom % 8);
        2:       a = 16'h0100 + 16'($urandom % 16'hFE00);
        default: a = {9'd0, 2'($urandom), 5'd0};
      endcase
      if ($urandom % 5 == 0) begin
        @(negedge clk); copied = 1'b1;
        @(negedge clk); copied = 1'b0;
        e_aa = 1'b1;
      end
      fill(11);
      run_cmd(($urandom % 8 == 0) ? 8'h3C : 8'h0F, a, int'($urandom % 11), 1'b0);
      check_all("R2 R4 R5 R7 R8 R9 R10 R11 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule